// File: doc/BRIEF.md
# Eight-Operation Selectable ALU

This block is a purely combinational arithmetic-logic unit. It takes two operands of equal width and a 3-bit operation code. It returns one result word and a single carry bit. The eight codes cover three arithmetic operations (add, subtract, increment), three two-operand bitwise operations (AND, OR, XOR), a one-operand inversion and a pass-through of the first operand.

All three arithmetic codes share one ripple adder. A small operand conditioner in front of the adder picks the second addend and the carry-in. Subtract feeds the inverted second operand with a carry-in of one. Increment feeds zero with a carry-in of one. The carry output shows the adder's carry only for arithmetic codes and is held at 0 for every other code. The block has no clock and no reset. It is meant to sit between pipeline registers that the surrounding datapath owns. Because of that it has no valid/ready handshake: a new operand set is accepted whenever the inputs change, and no back-pressure exists.

Top module: `opsel_alu`

## Requirements
- R1: Code 3'b000 makes the result equal to (A + B) mod 2^W, and carry_out equals the carry out of that sum.
- R2: Code 3'b001 makes the result equal to (A - B) mod 2^W, computed as A + ~B + 1. carry_out is 1 exactly when A >= B as unsigned values.
- R3: Code 3'b010 makes the result equal to A AND B, and code 3'b011 makes it equal to A OR B.
- R4: Code 3'b100 makes the result equal to A XOR B.
- R5: Code 3'b101 makes the result equal to the bitwise inverse of A. The value of B has no effect on result or carry_out.
- R6: Code 3'b110 makes the result equal to (A + 1) mod 2^W. carry_out is 1 only when A is all ones, in which case the result wraps to zero.
- R7: Code 3'b111 makes the result equal to A, unchanged.
- R8: For codes 3'b010, 3'b011, 3'b100, 3'b101 and 3'b111, carry_out is 0.
- R9: The block has no storage. Result and carry_out depend only on the present inputs and settle within the same cycle in which the inputs change.
- R10: The operand width W is a parameter with a default of 8, and every code behaves as above at that width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | W | First operand; the only operand used by NOT, increment and pass-through |
| opd_b | input | W | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | W | Result word |
| carry_out | output | 1 | Adder carry for add, inverted borrow for subtract, wrap for increment; 0 otherwise |

## Verification
The block holds no state, so a wrong internal value never lingers. It shows up at the ports in the same cycle as the operand set that triggers it. Faults are expected in the operand conditioner, the carry chain or the result selector. Such a fault appears either as a wrong result for one code, or as a carry leaking into a non-arithmetic code. For that reason every code is applied at the corner values 0, 1, all ones and MSB-only, where carries and borrows run the full chain.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_NOTA = 3'b101,
    OP_INC  = 3'b110,
    OP_PASS = 3'b111
  } op_e;

  function automatic logic op_is_arith(op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
  endfunction

endpackage

// File: rtl/opsel_alu_arith.sv
module opsel_alu_arith
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  op_e          op_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] addend;
  logic         cin;
  logic [W:0]   chain;

  // operand conditioning: one adder serves add, subtract and increment
  always_comb begin
    case (op_i)
      OP_SUB: begin
        addend = ~b_i;
        cin    = 1'b1;
      end
      OP_INC: begin
        addend = '0;
        cin    = 1'b1;
      end
      default: begin
        addend = b_i;
        cin    = 1'b0;
      end
    endcase
  end

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]    = a_i[i] ^ addend[i] ^ chain[i];
    assign chain[i+1]  = (a_i[i] & addend[i]) | (chain[i] & (a_i[i] ^ addend[i]));
  end

  assign cout_o = chain[W];

endmodule

// File: rtl/opsel_alu_logic.sv
module opsel_alu_logic
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  op_e          op_i,
  output logic [W-1:0] y_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (op_i)
        OP_AND:  y_o[i] = a_i[i] & b_i[i];
        OP_OR:   y_o[i] = a_i[i] | b_i[i];
        OP_XOR:  y_o[i] = a_i[i] ^ b_i[i];
        OP_NOTA: y_o[i] = ~a_i[i];
        default: y_o[i] = a_i[i];
      endcase
    end
  end

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_out
);

  op_e          op;
  logic [W-1:0] arith_y;
  logic         arith_c;
  logic [W-1:0] logic_y;
  logic         sel_arith;

  assign op = op_e'(op_sel);

  opsel_alu_arith #(.W(W)) u_arith (
    .a_i    (opd_a),
    .b_i    (opd_b),
    .op_i   (op),
    .sum_o  (arith_y),
    .cout_o (arith_c)
  );

  opsel_alu_logic #(.W(W)) u_logic (
    .a_i  (opd_a),
    .b_i  (opd_b),
    .op_i (op),
    .y_o  (logic_y)
  );

  assign sel_arith = op_is_arith(op);
  assign result    = sel_arith ? arith_y : logic_y;
  assign carry_out = sel_arith & arith_c;

endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opd_a,
  input logic [W-1:0] opd_b,
  input logic [2:0]   op_sel,
  input logic [W-1:0] result,
  input logic         carry_out
);

  logic known;
  assign known = !$isunknown({opd_a, opd_b, op_sel, result, carry_out});

  always_comb begin
    if (known) begin
      if (op_sel == 3'b000)
        p_add_r1: assert ({carry_out, result} == {1'b0, opd_a} + {1'b0, opd_b});
      if (op_sel == 3'b001)
        p_sub_r2: assert (result == opd_a - opd_b && carry_out == (opd_a >= opd_b));
      if (op_sel == 3'b010)
        p_and_r3: assert (result == (opd_a & opd_b));
      if (op_sel == 3'b011)
        p_or_r3: assert (result == (opd_a | opd_b));
      if (op_sel == 3'b100)
        p_xor_r4: assert (result == (opd_a ^ opd_b));
      if (op_sel == 3'b101)
        p_nota_r5: assert (result == ~opd_a);
      if (op_sel == 3'b110)
        p_inc_r6: assert (result == opd_a + 1'b1 && carry_out == (&opd_a));
      if (op_sel == 3'b111)
        p_pass_r7: assert (result == opd_a);
      if (op_sel[2:1] == 2'b01 || op_sel == 3'b100 || op_sel == 3'b101 || op_sel == 3'b111)
        p_no_carry_r8: assert (!carry_out);
    end
  end

endmodule

bind opsel_alu opsel_alu_chk #(.W(W)) u_chk (
  .opd_a     (opd_a),
  .opd_b     (opd_b),
  .op_sel    (op_sel),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/opsel_alu_tb.sv
module opsel_alu_tb;

  localparam int W = 8;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MSB  = {1'b1, {(W-1){1'b0}}};

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         cy;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] opd_a = '0;
  logic [W-1:0] opd_b = '0;
  logic [2:0]   op_sel = 3'b000;
  logic [W-1:0] result;
  logic         carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  item_t sb[$];

  opsel_alu #(.W(W)) u_dut (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out)
  );

  function automatic item_t model(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op);
    item_t it;
    logic [W:0] wide;
    it.a = a; it.b = b; it.op = op; it.cy = 1'b0;
    case (op)
      3'b000: begin wide = {1'b0, a} + {1'b0, b}; it.res = wide[W-1:0]; it.cy = wide[W]; it.tag = "R1"; end
      3'b001: begin it.res = a - b; it.cy = (a >= b); it.tag = "R2"; end
      3'b010: begin it.res = a & b; it.tag = "R3/R8"; end
      3'b011: begin it.res = a | b; it.tag = "R3/R8"; end
      3'b100: begin it.res = a ^ b; it.tag = "R4/R8"; end
      3'b101: begin it.res = ~a; it.tag = "R5/R8"; end
      3'b110: begin it.res = a + 1'b1; it.cy = (a == ONES); it.tag = "R6"; end
      default: begin it.res = a; it.tag = "R7/R8"; end
    endcase
    return it;
  endfunction

  // driver: applies an operand set after a rising edge and queues its expectation
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op, string tag);
    item_t it;
    @(posedge clk);
    opd_a = a; opd_b = b; op_sel = op;
    it = model(a, b, op);
    if (tag != "") it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares at the falling edge, same cycle as the inputs (R9)
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (result !== it.res || carry_out !== it.cy) begin
        n_fail++;
        $display("FAIL %s/R9/R10 op=%b a=%h b=%h: got res=%h cy=%b, expected res=%h cy=%b",
                 it.tag, it.op, it.a, it.b, result, carry_out, it.res, it.cy);
      end
    end
  end

  initial begin
    logic [W-1:0] corners [4];
    corners[0] = '0; corners[1] = 1; corners[2] = ONES; corners[3] = MSB;

    // idle state: all-zero inputs give zero result, no carry
    drive('0, '0, 3'b000, "R1 idle");

    // every code at the corner operands
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(corners[i], corners[j], 3'(op), "");

    // R6 wrap and R2 borrow edges
    drive(ONES, 8'h5A, 3'b110, "R6 wrap");
    drive(8'h10, 8'h11, 3'b001, "R2 borrow");
    drive(8'h11, 8'h11, 3'b001, "R2 equal");

    // R5: B has no effect on NOT
    for (int k = 0; k < 8; k++)
      drive(8'h3C, 8'(k * 37), 3'b101, "R5 b ignored");

    // random operands for every code
    for (int k = 0; k < 400; k++)
      drive(W'($urandom), W'($urandom), 3'(k % 8), "");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired: got hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule